// File: doc/BRIEF.md
# Three-Phase Rank-Ordered Leg State Selector

This block sits in a cascaded three-level inverter controller. On every sample strobe it takes the three signed phase-voltage samples and sorts them into highest, middle and lowest. The leg carrying the highest phase is tied to the positive rail (state P). The middle phase goes to the intermediate rail (state O). The lowest phase goes to the negative rail (state N). Each leg gets four switch enables that match its state. No carrier comparison is involved: a leg's rank among the phases sets its state.

The block also produces two line-voltage references for the front-end regulators. The bus reference is highest minus lowest. The midpoint reference is middle minus lowest. A pair of mode flags tells the midpoint regulator which path to use. When the midpoint reference is above a programmable threshold, the midpoint must source current through the forward buck path. Otherwise it must sink current through the negative buck path. All outputs are registered and change only after a strobe.

Top module: `phase_rank_sel`

## Requirements
- R1: The phase with the largest sample gets state code 2'b11 (P) on its state output. Its switch enables are 4'b0011, where bit 0 is switch 1 (outermost upper) and bit 3 is switch 4 (outermost lower).
- R2: The phase with the middle sample gets state code 2'b10 (O), with switch enables 4'b0110.
- R3: The phase with the smallest sample gets state code 2'b01 (N), with switch enables 4'b1100.
- R4: Equal samples are ranked with fixed priority, leg A above leg B above leg C. After any strobe, exactly one leg is in each of P, O and N.
- R5: `bus_ref` equals highest minus lowest sample as a SAMPLE_W+1 bit signed value. It is exact at full scale, for example 32767 − (−32768) = 65535.
- R6: `mid_ref` equals middle minus lowest sample as a SAMPLE_W+1 bit signed value.
- R7: `src_mode` is 1 and `snk_mode` is 0 when `mid_ref` is strictly greater than MID_THRESH. Otherwise `snk_mode` is 1 and `src_mode` is 0.
- R8: The outputs take the new values one clock after a cycle with `smp_vld` high. In cycles without a strobe they hold, whatever the sample inputs do.
- R9: While `rst_n` is low, and until the first strobe, the following are all zero: state codes (2'b00, idle), switch enables, both references and both mode flags.
- R10: With three balanced sinusoids 120° apart, strobed through one full period, each leg changes state exactly four times, in the order P, O, N, O, P.
- R11: No leg ever has switch 1 and switch 4 enabled together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe; the samples are taken on this edge |
| va | input | SAMPLE_W | Signed phase A sample |
| vb | input | SAMPLE_W | Signed phase B sample |
| vc | input | SAMPLE_W | Signed phase C sample |
| st_a | output | 2 | Leg A state code (00 idle, 01 N, 10 O, 11 P) |
| st_b | output | 2 | Leg B state code |
| st_c | output | 2 | Leg C state code |
| sw_a | output | 4 | Leg A switch enables, bit 0 = switch 1 |
| sw_b | output | 4 | Leg B switch enables |
| sw_c | output | 4 | Leg C switch enables |
| bus_ref | output | SAMPLE_W+1 | Signed highest-minus-lowest reference |
| mid_ref | output | SAMPLE_W+1 | Signed middle-minus-lowest reference |
| src_mode | output | 1 | Midpoint must source current (forward buck path) |
| snk_mode | output | 1 | Midpoint must sink current (negative buck path) |

## Verification
Several rules are checked on every cycle:
- no leg has its outer switches on together;
- once sampled, each leg shows one of the three legal switch patterns, and exactly one leg is in each state;
- the two mode flags are mutually exclusive;
- the bus reference is never below the midpoint reference, and the midpoint reference is never negative;
- outputs hold when there is no strobe.

Other behaviours can only be shown by the bench's scenarios:
- that the correct leg wins the ranking, including the A-over-B-over-C tie order;
- that the references are exact at full scale;
- that the flag flips exactly at the threshold boundary;
- that a sinusoidal sweep gives four transitions per leg.

// File: rtl/phsel_pkg.sv
package phsel_pkg;

   typedef enum logic [1:0] {
      LEG_IDLE = 2'b00,
      LEG_N    = 2'b01,
      LEG_O    = 2'b10,
      LEG_P    = 2'b11
   } leg_st_e;

   localparam int NUM_LEGS = 3;

endpackage

// File: rtl/phsel_rank.sv
// Ranks three signed samples; ties resolved with leg 0 > leg 1 > leg 2.
module phsel_rank
   import phsel_pkg::*;
#(
   parameter int W = 16
) (
   input  logic signed [W-1:0] v_i   [NUM_LEGS],
   output leg_st_e             st_o  [NUM_LEGS],
   output logic [1:0]          idx_h_o,
   output logic [1:0]          idx_m_o,
   output logic [1:0]          idx_l_o
);

   logic a_ob, a_oc, b_oc;
   logic [1:0] wins [NUM_LEGS];

   // Greater-or-equal gives the lower-indexed leg the win on a tie.
   assign a_ob = (v_i[0] >= v_i[1]);
   assign a_oc = (v_i[0] >= v_i[2]);
   assign b_oc = (v_i[1] >= v_i[2]);

   assign wins[0] = {1'b0, a_ob}  + {1'b0, a_oc};
   assign wins[1] = {1'b0, ~a_ob} + {1'b0, b_oc};
   assign wins[2] = {1'b0, ~a_oc} + {1'b0, ~b_oc};

   always_comb begin
      idx_h_o = 2'd0;
      idx_m_o = 2'd1;
      idx_l_o = 2'd2;
      for (int i = 0; i < NUM_LEGS; i++) begin
         case (wins[i])
            2'd2:    begin st_o[i] = LEG_P; idx_h_o = 2'(i); end
            2'd1:    begin st_o[i] = LEG_O; idx_m_o = 2'(i); end
            default: begin st_o[i] = LEG_N; idx_l_o = 2'(i); end
         endcase
      end
   end

endmodule

// File: rtl/phsel_refs.sv
// Line-voltage references from the ranked samples, widened by one bit.
module phsel_refs
   import phsel_pkg::*;
#(
   parameter int W = 16
) (
   input  logic signed [W-1:0] v_i [NUM_LEGS],
   input  logic [1:0]          idx_h_i,
   input  logic [1:0]          idx_m_i,
   input  logic [1:0]          idx_l_i,
   output logic signed [W:0]   bus_o,
   output logic signed [W:0]   mid_o
);

   function automatic logic signed [W:0] pick(input logic signed [W-1:0] v [NUM_LEGS],
                                              input logic [1:0] idx);
      case (idx)
         2'd0:    return {v[0][W-1], v[0]};
         2'd1:    return {v[1][W-1], v[1]};
         default: return {v[2][W-1], v[2]};
      endcase
   endfunction

   logic signed [W:0] hi_x, md_x, lo_x;

   assign hi_x  = pick(v_i, idx_h_i);
   assign md_x  = pick(v_i, idx_m_i);
   assign lo_x  = pick(v_i, idx_l_i);
   assign bus_o = hi_x - lo_x;
   assign mid_o = md_x - lo_x;

endmodule

// File: rtl/phsel_leg.sv
// Per-leg decode of the rail state into four switch enables.
module phsel_leg
   import phsel_pkg::*;
(
   input  leg_st_e    st_i,
   output logic [3:0] sw_o
);

   always_comb begin
      case (st_i)
         LEG_P:   sw_o = 4'b0011;
         LEG_O:   sw_o = 4'b0110;
         LEG_N:   sw_o = 4'b1100;
         default: sw_o = 4'b0000;
      endcase
   end

endmodule

// File: rtl/phase_rank_sel.sv
module phase_rank_sel
   import phsel_pkg::*;
#(
   parameter int SAMPLE_W   = 16,
   parameter int MID_THRESH = 14189
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        smp_vld,
   input  logic signed [SAMPLE_W-1:0]  va,
   input  logic signed [SAMPLE_W-1:0]  vb,
   input  logic signed [SAMPLE_W-1:0]  vc,
   output logic [1:0]                  st_a,
   output logic [1:0]                  st_b,
   output logic [1:0]                  st_c,
   output logic [3:0]                  sw_a,
   output logic [3:0]                  sw_b,
   output logic [3:0]                  sw_c,
   output logic signed [SAMPLE_W:0]    bus_ref,
   output logic signed [SAMPLE_W:0]    mid_ref,
   output logic                        src_mode,
   output logic                        snk_mode
);

   localparam int REF_W = SAMPLE_W + 1;
   localparam logic signed [REF_W-1:0] THR = REF_W'(MID_THRESH);

   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 30) begin : g_bad_width
         $error("phase_rank_sel: SAMPLE_W out of range");
      end
      if (MID_THRESH < 0 || MID_THRESH >= (1 << SAMPLE_W)) begin : g_bad_thresh
         $error("phase_rank_sel: MID_THRESH outside reference range");
      end
   endgenerate

   logic signed [SAMPLE_W-1:0] v [NUM_LEGS];
   leg_st_e                    st_d [NUM_LEGS];
   leg_st_e                    st_q [NUM_LEGS];
   logic [1:0]                 idx_h, idx_m, idx_l;
   logic signed [REF_W-1:0]    bus_d, mid_d;
   logic [3:0]                 sw [NUM_LEGS];

   assign v[0] = va;
   assign v[1] = vb;
   assign v[2] = vc;

   phsel_rank #(.W(SAMPLE_W)) u_rank (
      .v_i     (v),
      .st_o    (st_d),
      .idx_h_o (idx_h),
      .idx_m_o (idx_m),
      .idx_l_o (idx_l)
   );

   phsel_refs #(.W(SAMPLE_W)) u_refs (
      .v_i     (v),
      .idx_h_i (idx_h),
      .idx_m_i (idx_m),
      .idx_l_i (idx_l),
      .bus_o   (bus_d),
      .mid_o   (mid_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LEGS; i++) st_q[i] <= LEG_IDLE;
         bus_ref  <= '0;
         mid_ref  <= '0;
         src_mode <= 1'b0;
         snk_mode <= 1'b0;
      end else if (smp_vld) begin
         for (int i = 0; i < NUM_LEGS; i++) st_q[i] <= st_d[i];
         bus_ref  <= bus_d;
         mid_ref  <= mid_d;
         src_mode <= (mid_d > THR);
         snk_mode <= !(mid_d > THR);
      end
   end

   generate
      for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
         phsel_leg u_leg (
            .st_i (st_q[g]),
            .sw_o (sw[g])
         );
      end
   endgenerate

   assign st_a = st_q[0];
   assign st_b = st_q[1];
   assign st_c = st_q[2];
   assign sw_a = sw[0];
   assign sw_b = sw[1];
   assign sw_c = sw[2];

endmodule

// File: rtl/phsel_chk.sv
module phsel_chk #(
   parameter int W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                smp_vld,
   input logic [1:0]          st_a,
   input logic [1:0]          st_b,
   input logic [1:0]          st_c,
   input logic [3:0]          sw_a,
   input logic [3:0]          sw_b,
   input logic [3:0]          sw_c,
   input logic signed [W:0]   bus_ref,
   input logic signed [W:0]   mid_ref,
   input logic                src_mode,
   input logic                snk_mode
);

   logic seen;
   always_ff @(posedge clk) begin
      if (!rst_n) seen <= 1'b0;
      else if (smp_vld) seen <= 1'b1;
   end

   function automatic logic legal_sw(input logic [3:0] s);
      return (s == 4'b0011) || (s == 4'b0110) || (s == 4'b1100);
   endfunction

   logic [2:0] is_p, is_o, is_n;
   assign is_p = {sw_c == 4'b0011, sw_b == 4'b0011, sw_a == 4'b0011};
   assign is_o = {sw_c == 4'b0110, sw_b == 4'b0110, sw_a == 4'b0110};
   assign is_n = {sw_c == 4'b1100, sw_b == 4'b1100, sw_a == 4'b1100};

   // R11
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_a[0] && sw_a[3]) && !(sw_b[0] && sw_b[3]) && !(sw_c[0] && sw_c[3]));

   // R1 R2 R3
   legal_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (legal_sw(sw_a) && legal_sw(sw_b) && legal_sw(sw_c)));

   // R4
   one_each_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> ($countones(is_p) == 1 && $countones(is_o) == 1 && $countones(is_n) == 1));

   // R7
   mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (src_mode != snk_mode));

   // R5 R6
   ref_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> (bus_ref >= mid_ref && mid_ref >= 0));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable({st_a, st_b, st_c, bus_ref, mid_ref, src_mode, snk_mode}));

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> ({st_a, st_b, st_c} == 6'd0 && !src_mode && !snk_mode));

endmodule

bind phase_rank_sel phsel_chk #(.W(SAMPLE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_vld  (smp_vld),
   .st_a     (st_a),
   .st_b     (st_b),
   .st_c     (st_c),
   .sw_a     (sw_a),
   .sw_b     (sw_b),
   .sw_c     (sw_c),
   .bus_ref  (bus_ref),
   .mid_ref  (mid_ref),
   .src_mode (src_mode),
   .snk_mode (snk_mode)
);

// File: tb/test_phase_rank_sel.sv
`timescale 1ns/1ps
module test_phase_rank_sel;

   localparam int W   = 16;
   localparam int THR = 14189;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic signed [W-1:0] va = '0, vb = '0, vc = '0;
   logic [1:0] st_a, st_b, st_c;
   logic [3:0] sw_a, sw_b, sw_c;
   logic signed [W:0] bus_ref, mid_ref;
   logic src_mode, snk_mode;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   phase_rank_sel #(.SAMPLE_W(W), .MID_THRESH(THR)) i_phase_rank_sel (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
      .va(va), .vb(vb), .vc(vc),
      .st_a(st_a), .st_b(st_b), .st_c(st_c),
      .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c),
      .bus_ref(bus_ref), .mid_ref(mid_ref),
      .src_mode(src_mode), .snk_mode(snk_mode)
   );

   // reference model
   int e_st [3];
   int e_bus, e_mid;
   bit e_src, e_snk;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) e_st[i] = 0;
         e_bus = 0; e_mid = 0; e_src = 0; e_snk = 0;
      end else if (smp_vld) begin
         int v [3];
         int p, n, o;
         v[0] = int'(va); v[1] = int'(vb); v[2] = int'(vc);
         p = 0;
         for (int i = 1; i < 3; i++) if (v[i] > v[p]) p = i;
         n = 2;
         for (int i = 1; i >= 0; i--) if (v[i] < v[n]) n = i;
         o = 3 - p - n;
         e_st[p] = 3; e_st[o] = 2; e_st[n] = 1;
         e_bus = v[p] - v[n];
         e_mid = v[o] - v[n];
         e_src = (e_mid > THR);
         e_snk = !(e_mid > THR);
      end
   end

   function automatic int sw_exp(input int s);
      case (s)
         3: return 4'b0011;
         2: return 4'b0110;
         1: return 4'b1100;
         default: return 0;
      endcase
   endfunction

   function automatic string st_tag(input int s);
      case (s)
         3: return "R1";
         2: return "R2";
         1: return "R3";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s got=%0d exp=%0d t=%0t", tag, what, got, exp, $time);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      cycles++;
      chk(st_tag(e_st[0]), "st_a", int'(st_a), e_st[0]);
      chk(st_tag(e_st[1]), "st_b", int'(st_b), e_st[1]);
      chk(st_tag(e_st[2]), "st_c", int'(st_c), e_st[2]);
      chk(st_tag(e_st[0]), "sw_a", int'(sw_a), sw_exp(e_st[0]));
      chk(st_tag(e_st[1]), "sw_b", int'(sw_b), sw_exp(e_st[1]));
      chk(st_tag(e_st[2]), "sw_c", int'(sw_c), sw_exp(e_st[2]));
      chk("R5", "bus_ref", int'(bus_ref), e_bus);
      chk("R6", "mid_ref", int'(mid_ref), e_mid);
      chk("R7", "src_mode", int'(src_mode), int'(e_src));
      chk("R7", "snk_mode", int'(snk_mode), int'(e_snk));
      chk("R11", "outer pair", int'((sw_a[0] & sw_a[3]) | (sw_b[0] & sw_b[3]) | (sw_c[0] & sw_c[3])), 0);
      if (cycles > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic strobe(input int a, input int b, input int c);
      @(negedge clk);
      va = W'(a); vb = W'(b); vc = W'(c);
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   initial begin
      int prev, changes;
      int seq [6];
      int nseq;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "reset st", int'({st_a, st_b, st_c}), 0);
      chk("R9", "reset sw", int'({sw_a, sw_b, sw_c}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "pre-strobe flags", int'({src_mode, snk_mode}), 0);

      // all orderings (R1 R2 R3)
      strobe(300, 200, 100);
      chk("R1", "A high", int'(st_a), 3);
      strobe(100, 300, 200);
      chk("R1", "B high", int'(st_b), 3);
      strobe(200, 100, 300);
      chk("R3", "B low", int'(st_b), 1);
      strobe(-5, 7, -9);
      strobe(0, -1, 1);
      strobe(-300, -100, -200);
      chk("R2", "C mid", int'(st_c), 2);

      // ties (R4)
      strobe(5, 5, 1);
      chk("R4", "A over B", int'({st_a, st_b}), {2'b11, 2'b10});
      strobe(1, 5, 5);
      chk("R4", "B over C", int'({st_b, st_c}), {2'b11, 2'b10});
      strobe(1, 9, 1);
      chk("R4", "A over C", int'({st_a, st_c}), {2'b10, 2'b01});
      strobe(42, 42, 42);
      chk("R4", "all equal", int'({st_a, st_b, st_c}), {2'b11, 2'b10, 2'b01});

      // full scale (R5)
      strobe(32767, 0, -32768);
      chk("R5", "full-scale bus", int'(bus_ref), 65535);
      strobe(-32768, 32767, 32767);
      chk("R6", "full-scale mid", int'(mid_ref), 65535);

      // threshold boundary (R7)
      strobe(20000, THR, 0);
      chk("R7", "at threshold sinks", int'({src_mode, snk_mode}), 1);
      strobe(20000, THR + 1, 0);
      chk("R7", "above threshold sources", int'({src_mode, snk_mode}), 2);

      // hold without strobe (R8)
      strobe(10, 20, 30);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         va = W'(k * 1000 + 5000); vb = W'(-k * 700); vc = W'(k);
      end
      @(negedge clk);
      chk("R8", "hold st", int'({st_a, st_b, st_c}), {2'b01, 2'b10, 2'b11});
      chk("R8", "hold bus", int'(bus_ref), 20);

      // random patterns
      for (int k = 0; k < 300; k++)
         strobe(int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768,
                int'($urandom_range(65535)) - 32768);

      // sinusoidal sweep (R10)
      changes = 0; nseq = 0; prev = -1;
      for (int k = 0; k <= 96; k++) begin
         real th;
         th = 2.0 * 3.14159265358979 * k / 96.0;
         strobe($rtoi(30000.0 * $sin(th)),
                $rtoi(30000.0 * $sin(th - 2.0943951023932)),
                $rtoi(30000.0 * $sin(th + 2.0943951023932)));
         if (prev >= 0 && int'(st_a) != prev) begin
            changes++;
            if (nseq < 6) begin seq[nseq] = int'(st_a); nseq++; end
         end
         prev = int'(st_a);
      end
      chk("R10", "leg A changes per period", changes, 4);
      if (nseq >= 4) begin
         chk("R10", "order 1", seq[0], 3);
         chk("R10", "order 2", seq[1], 2);
         chk("R10", "order 3", seq[2], 1);
         chk("R10", "order 4", seq[3], 2);
      end

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule